// File: doc/BRIEF.md
# Conditional Move Commit Unit

This unit decides whether a conditional register move commits its source operand, and turns that decision into one write on a lane-masked register-file port. It takes a 4-bit condition code, the five arithmetic flags, an operand size (16 or 32 bits), a 64-bit mode flag, a destination index and a source operand. The source comes either from a register, delivered with the request, or from memory, fetched through a valid/ready read handshake.

A memory operand is always fetched, even when the condition turns out false, so a fault on that read stays observable. While the read is pending, the request fields are held in internal registers and the request inputs are ignored. A 32-bit move in 64-bit mode always clears the upper half of the destination. A 16-bit move never touches anything above its low 16 bits. Each request ends with a one-cycle `done` pulse, and `taken` reports the condition result.

Top module: `cmov_unit`

## Requirements
- R1: Flags input bits are CF=bit0, PF=bit1, ZF=bit2, SF=bit3, OF=bit4. Codes 0/1 test OF set/clear, 2/3 test CF set/clear and 4/5 test ZF set/clear.
- R2: Code 6 is true when CF or ZF is set. Code 7 is true when CF and ZF are both clear.
- R3: Codes 8/9 test SF set/clear. Codes 10/11 test PF set/clear.
- R4: Code 12 is true when SF differs from OF. Code 13 is true when SF equals OF.
- R5: Code 14 is true when ZF is set or SF differs from OF. Code 15 is true when ZF is clear and SF equals OF.
- R6: A request with `req_from_mem`=1 raises `rd_req` in the cycle after acceptance and holds it until `rd_valid`. This happens whatever the condition result is.
- R7: A request with `req_from_mem`=0 never raises `rd_req`. Its result appears in the cycle after acceptance.
- R8: `done` and any write are a single-cycle pulse in the cycle after the operand is available, either at acceptance or at `rd_valid`. The write uses the requested destination index.
- R9: A 16-bit move (`req_wide`=0) writes only lane 0 (`wr_lanes`=0001, bits 15:0) with the source's low 16 bits when taken. When not taken, it does not write.
- R10: A 32-bit move in 64-bit mode always writes. When taken, it uses lanes 1111 with the zero-extended source. When not taken, it uses lanes 1100 with zero data.
- R11: A 32-bit move outside 64-bit mode writes lanes 0011 with the source when taken. When not taken, it does not write.
- R12: While a memory read is pending, changes on the request inputs have no effect on the result.
- R13: `req_ready` is low while a memory read is pending and high otherwise after reset. `taken` accompanies `done` and equals the condition result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_cond | input | 4 | Condition code |
| req_flags | input | 5 | Arithmetic flags {OF,SF,ZF,PF,CF} |
| req_from_mem | input | 1 | Source is in memory |
| req_reg_src | input | 32 | Register source operand |
| req_dst | input | 4 | Destination register index |
| req_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| req_long | input | 1 | 64-bit mode |
| rd_req | output | 1 | Memory read requested |
| rd_valid | input | 1 | Memory read data valid |
| rd_data | input | 32 | Memory read data |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 64 | Register write data |
| wr_lanes | output | 4 | 16-bit lane enables of the write |
| done | output | 1 | Request finished |
| taken | output | 1 | Condition held for the finished request |

## Verification
For a register source, `done` and the write are due exactly one cycle after the accepting edge. For a memory source, they are due one cycle after the edge that samples `rd_valid`, and `rd_req` must already be high in the cycle after acceptance. The driver drives inputs on falling edges and pushes the expected write into a queue at issue time. The monitor pops the queue only on the falling edge where `done` is high and compares index, lanes and data there. An unexpected `done`, a write without `done`, or leftover entries counts as a failure. Pending reads are stretched by 0 to 7 cycles, with the request inputs inverted meanwhile, to confirm that the latched fields are the ones used.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

  // Flag vector layout: bit0 CF, bit1 PF, bit2 ZF, bit3 SF, bit4 OF
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } flags_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_t;

endpackage

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
(
  input  flags_t     fl,
  input  logic [3:0] code,
  output logic       hit
);

  logic base;
  logic sgn_lt;

  // Code bits 3:1 pick a predicate, bit 0 inverts it
  always_comb begin
    sgn_lt = fl.sf ^ fl.of;
    unique case (code[3:1])
      3'd0: base = fl.of;
      3'd1: base = fl.cf;
      3'd2: base = fl.zf;
      3'd3: base = fl.cf | fl.zf;
      3'd4: base = fl.sf;
      3'd5: base = fl.pf;
      3'd6: base = sgn_lt;
      default: base = fl.zf | sgn_lt;
    endcase
    hit = base ^ code[0];
  end

endmodule

// File: rtl/cmov_wr_form.sv
module cmov_wr_form #(
  parameter int LANE_W       = 16,
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 1,
  parameter int WIDE_LANES   = 2
) (
  input  logic                          hit,
  input  logic                          wide,
  input  logic                          long_mode,
  input  logic [WIDE_LANES*LANE_W-1:0]  src,
  output logic [LANES-1:0]              lane_en,
  output logic [LANES-1:0][LANE_W-1:0]  lane_dat,
  output logic                          any_en
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < NARROW_LANES) begin : g_low
      always_comb begin
        lane_en[k]  = hit;
        lane_dat[k] = hit ? src[k*LANE_W +: LANE_W] : '0;
      end
    end else if (k < WIDE_LANES) begin : g_mid
      always_comb begin
        lane_en[k]  = hit & wide;
        lane_dat[k] = (hit & wide) ? src[k*LANE_W +: LANE_W] : '0;
      end
    end else begin : g_up
      // upper half is cleared by every 32-bit move in 64-bit mode
      always_comb begin
        lane_en[k]  = wide & long_mode;
        lane_dat[k] = '0;
      end
    end
  end

  assign any_en = |lane_en;

endmodule

// File: rtl/cmov_seq.sv
module cmov_seq
  import cmov_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cond,
  input  flags_t            req_flags,
  input  logic              req_from_mem,
  input  logic [SRC_W-1:0]  req_reg_src,
  input  logic [IDX_W-1:0]  req_dst,
  input  logic              req_wide,
  input  logic              req_long,
  input  logic              rd_valid,
  input  logic [SRC_W-1:0]  rd_data,
  output logic              req_ready,
  output logic              rd_req,
  output flags_t            ev_flags,
  output logic [3:0]        ev_code,
  output logic              op_fire,
  output logic [SRC_W-1:0]  op_src,
  output logic [IDX_W-1:0]  op_dst,
  output logic              op_wide,
  output logic              op_long
);

  seq_state_t       state_q, state_d;
  flags_t           lat_flags;
  logic [3:0]       lat_code;
  logic [IDX_W-1:0] lat_dst;
  logic             lat_wide;
  logic             lat_long;
  logic             accept;
  logic             lat_en;

  assign req_ready = (state_q == ST_IDLE);
  assign rd_req    = (state_q == ST_WAIT);
  assign accept    = req_valid & req_ready;
  assign lat_en    = accept & req_from_mem;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (lat_en)   state_d = ST_WAIT;
      ST_WAIT: if (rd_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request fields held for the duration of the memory read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_flags <= '0;
      lat_code  <= '0;
      lat_dst   <= '0;
      lat_wide  <= 1'b0;
      lat_long  <= 1'b0;
    end else if (lat_en) begin
      lat_flags <= req_flags;
      lat_code  <= req_cond;
      lat_dst   <= req_dst;
      lat_wide  <= req_wide;
      lat_long  <= req_long;
    end
  end

  always_comb begin
    if (state_q == ST_WAIT) begin
      ev_flags = lat_flags;
      ev_code  = lat_code;
      op_fire  = rd_valid;
      op_src   = rd_data;
      op_dst   = lat_dst;
      op_wide  = lat_wide;
      op_long  = lat_long;
    end else begin
      ev_flags = req_flags;
      ev_code  = req_cond;
      op_fire  = accept & ~req_from_mem;
      op_src   = req_reg_src;
      op_dst   = req_dst;
      op_wide  = req_wide;
      op_long  = req_long;
    end
  end

  AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req);                                  // R6
  AST_MEM_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> rd_req);                                                 // R6
  AST_REG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_from_mem) |=> !rd_req);                             // R7
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> ($stable(lat_flags) && $stable(lat_code))); // R12

endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
  import cmov_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int LANES      = 4,
  parameter int WIDE_LANES = 2,
  parameter int IDX_W      = 4,
  localparam int SRC_W     = LANE_W * WIDE_LANES,
  localparam int REG_W     = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cond,
  input  logic [4:0]        req_flags,
  input  logic              req_from_mem,
  input  logic [SRC_W-1:0]  req_reg_src,
  input  logic [IDX_W-1:0]  req_dst,
  input  logic              req_wide,
  input  logic              req_long,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [SRC_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [REG_W-1:0]  wr_data,
  output logic [LANES-1:0]  wr_lanes,
  output logic              done,
  output logic              taken
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  flags_t                       ev_flags;
  logic [3:0]                   ev_code;
  logic                         op_fire;
  logic [SRC_W-1:0]             op_src;
  logic [IDX_W-1:0]             op_dst;
  logic                         op_wide;
  logic                         op_long;
  logic                         hit;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][LANE_W-1:0] lane_dat;
  logic                         any_en;

  cmov_seq #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_ni),
    .req_valid    (req_valid),
    .req_cond     (req_cond),
    .req_flags    (flags_t'(req_flags)),
    .req_from_mem (req_from_mem),
    .req_reg_src  (req_reg_src),
    .req_dst      (req_dst),
    .req_wide     (req_wide),
    .req_long     (req_long),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .req_ready    (req_ready),
    .rd_req       (rd_req),
    .ev_flags     (ev_flags),
    .ev_code      (ev_code),
    .op_fire      (op_fire),
    .op_src       (op_src),
    .op_dst       (op_dst),
    .op_wide      (op_wide),
    .op_long      (op_long)
  );

  cmov_cond_eval u_cond (
    .fl   (ev_flags),
    .code (ev_code),
    .hit  (hit)
  );

  cmov_wr_form #(
    .LANE_W       (LANE_W),
    .LANES        (LANES),
    .NARROW_LANES (1),
    .WIDE_LANES   (WIDE_LANES)
  ) u_form (
    .hit       (hit),
    .wide      (op_wide),
    .long_mode (op_long),
    .src       (op_src),
    .lane_en   (lane_en),
    .lane_dat  (lane_dat),
    .any_en    (any_en)
  );

  logic             wr_en_d, done_d, taken_d;
  logic [IDX_W-1:0] wr_idx_d;
  logic [REG_W-1:0] wr_data_d;
  logic [LANES-1:0] wr_lanes_d;

  always_comb begin
    done_d     = op_fire;
    taken_d    = op_fire & hit;
    wr_en_d    = op_fire & any_en;
    wr_idx_d   = op_fire ? op_dst : wr_idx;
    wr_lanes_d = op_fire ? lane_en : '0;
    wr_data_d  = op_fire ? REG_W'(lane_dat) : wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en    <= 1'b0;
      done     <= 1'b0;
      taken    <= 1'b0;
      wr_idx   <= '0;
      wr_lanes <= '0;
      wr_data  <= '0;
    end else begin
      wr_en    <= wr_en_d;
      done     <= done_d;
      taken    <= taken_d;
      wr_lanes <= wr_lanes_d;
      wr_idx   <= wr_idx_d;
      wr_data  <= wr_data_d;
    end
  end

  AST_WRITE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> done);                                                    // R8
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && rd_valid) |=> done);                                     // R8
  AST_LANES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> (wr_lanes != '0));                                        // R9
  AST_TAKEN_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    taken |-> done);                                                    // R13
  AST_NOT_TAKEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !taken) |-> (wr_lanes[0] == 1'b0 && wr_data == '0));      // R10

endmodule

// File: tb/sim_cmov_unit.sv
module sim_cmov_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cond = '0;
  logic [4:0]  req_flags = '0;
  logic        req_from_mem = 1'b0;
  logic [31:0] req_reg_src = '0;
  logic [3:0]  req_dst = '0;
  logic        req_wide = 1'b0;
  logic        req_long = 1'b0;
  logic        rd_req;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic [3:0]  wr_lanes;
  logic        done;
  logic        taken;

  always #2.5 clk = ~clk;

  cmov_unit u0 (.*);

  typedef struct {
    logic        en;
    logic [3:0]  idx;
    logic [63:0] data;
    logic [3:0]  lanes;
    logic        tk;
    string       req;
  } exp_t;

  exp_t exq[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 0;

  function automatic logic cond_ok(input logic [3:0] c, input logic [4:0] f);
    logic of, sf, zf, pf, cf;
    {of, sf, zf, pf, cf} = f;
    case (c)
      4'h0: return of;          4'h1: return !of;
      4'h2: return cf;          4'h3: return !cf;
      4'h4: return zf;          4'h5: return !zf;
      4'h6: return cf || zf;    4'h7: return !cf && !zf;
      4'h8: return sf;          4'h9: return !sf;
      4'hA: return pf;          4'hB: return !pf;
      4'hC: return sf != of;    4'hD: return sf == of;
      4'hE: return zf || (sf != of);
      default: return !zf && (sf == of);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic w, input logic l);
    string s;
    if (c < 6)       s = "R1";
    else if (c < 8)  s = "R2";
    else if (c < 12) s = "R3";
    else if (c < 14) s = "R4";
    else             s = "R5";
    if (!w)          s = {s, "/R9"};
    else if (l)      s = {s, "/R10"};
    else             s = {s, "/R11"};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en && !done)
        check(0, "R8", "write without done", 64'(wr_en), 64'(0));
      if (done) begin
        if (exq.size() == 0) begin
          check(0, "R8", "unexpected done", 64'(done), 64'(0));
        end else begin
          exp_t e;
          e = exq.pop_front();
          check(taken == e.tk, {e.req, "/R13"}, "taken", 64'(taken), 64'(e.tk));
          check(wr_en == e.en, e.req, "wr_en", 64'(wr_en), 64'(e.en));
          if (e.en && wr_en) begin
            check(wr_idx == e.idx, {e.req, "/R8"}, "wr_idx", 64'(wr_idx), 64'(e.idx));
            check(wr_lanes == e.lanes, e.req, "wr_lanes", 64'(wr_lanes), 64'(e.lanes));
            check(wr_data == e.data, e.req, "wr_data", wr_data, e.data);
          end
        end
      end
    end
  end

  task automatic issue(input logic [3:0] c, input logic [4:0] f, input bit mem,
                       input logic [31:0] src, input logic [3:0] dst,
                       input bit w, input bit l, input int dly, input bit scramble);
    exp_t e;
    logic t;
    t       = cond_ok(c, f);
    e.tk    = t;
    e.idx   = dst;
    e.req   = req_of(c, w, l);
    if (!w) begin
      e.en = t; e.lanes = t ? 4'b0001 : 4'b0000; e.data = t ? {48'h0, src[15:0]} : '0;
    end else if (l) begin
      e.en = 1; e.lanes = t ? 4'b1111 : 4'b1100; e.data = t ? {32'h0, src} : '0;
    end else begin
      e.en = t; e.lanes = t ? 4'b0011 : 4'b0000; e.data = t ? {32'h0, src} : '0;
    end
    @(negedge clk);
    req_valid = 1; req_cond = c; req_flags = f; req_from_mem = mem;
    req_reg_src = mem ? ~src : src; req_dst = dst; req_wide = w; req_long = l;
    exq.push_back(e);
    @(negedge clk);
    req_valid = 0;
    if (!mem) begin
      check(rd_req == 0, "R7", "rd_req on register source", 64'(rd_req), 64'(0));
    end else begin
      if (scramble) begin
        req_cond = ~c; req_flags = ~f; req_dst = ~dst; req_wide = ~w; req_long = ~l;
        req_reg_src = ~req_reg_src;
      end
      for (int k = 0; k < dly; k++) begin
        check(rd_req == 1, "R6", "rd_req pending", 64'(rd_req), 64'(1));
        check(req_ready == 0, "R13", "ready while waiting", 64'(req_ready), 64'(0));
        check(done == 0, "R12", "early done", 64'(done), 64'(0));
        @(negedge clk);
      end
      check(rd_req == 1, "R6", "rd_req before data", 64'(rd_req), 64'(1));
      rd_valid = 1; rd_data = src;
      @(negedge clk);
      rd_valid = 0; rd_data = '0;
      check(rd_req == 0, "R6", "rd_req after data", 64'(rd_req), 64'(0));
    end
  endtask

  initial begin
    #(200000 * 5);
    check(0, "R8", "watchdog expired", 64'(0), 64'(1));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr_en == 0 && done == 0 && rd_req == 0, "R13", "reset outputs",
          {61'h0, wr_en, done, rd_req}, 64'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R13", "ready after reset", 64'(req_ready), 64'(1));

    // every code against every flag pattern, register source
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        issue(4'(c), 5'(f), 0, 32'hA5C3_0000 ^ {16'(c * 97), 16'(f * 131 + 7)},
              4'(c ^ f), ((c + f) % 3) != 0, ((c + f) % 3) == 2, 0, 0);

    // memory source: false and true conditions, various latencies
    issue(4'h4, 5'b00000, 1, 32'h1234_5678, 4'd3, 1, 1, 0, 0);  // false, long: clear upper
    issue(4'h4, 5'b00100, 1, 32'h1234_5678, 4'd3, 1, 1, 3, 0);  // true, long
    issue(4'hC, 5'b10000, 1, 32'hDEAD_BEEF, 4'd9, 0, 1, 2, 1);  // 16-bit, scrambled wait
    issue(4'hF, 5'b11000, 1, 32'hCAFE_F00D, 4'd7, 1, 0, 7, 1);  // true, 32-bit non-long
    issue(4'h7, 5'b00001, 1, 32'h0BAD_0BAD, 4'd1, 1, 0, 1, 1);  // false: read still issued
    issue(4'hE, 5'b01000, 1, 32'h5555_AAAA, 4'd15, 1, 1, 5, 1); // true, scrambled
    issue(4'hB, 5'b00010, 1, 32'h7777_8888, 4'd2, 0, 0, 0, 0);  // false 16-bit
    issue(4'h2, 5'b00001, 0, 32'h0102_0304, 4'd4, 1, 1, 0, 0);  // register after memory

    repeat (4) @(negedge clk);
    check(exq.size() == 0, "R8", "results outstanding", 64'(exq.size()), 64'(0));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule